// File: doc/BRIEF.md
# Packet Page Allocator MMU

This block manages buffer memory inside a network controller. The memory is a pool of fixed-size pages, 2048 bytes each. A bitmask records which pages are in use. Every allocation hands out the lowest-numbered free page. Page numbers travel through three short queues:
- a transmit queue of pages waiting to be sent;
- a completion queue of pages that have been sent;
- a receive queue of pages holding arrived frames.

The host writes a command byte whose top three bits select an operation. The operations allocate, release and reset, and they push to or pop from the queues. A separate packet-number register names the page that release and push commands act on. When a transmit allocate finds the pool full, it is remembered. It is retried in the cycle that any page is freed. The receive side asks for pages through its own request line. The transmit engine reports each sent frame through a "sent" strobe. The host acknowledges completions through an ack strobe.

All state is registered. Every operation takes effect at the rising clock edge on which it is presented. Its results are visible on the status outputs immediately after that edge.

Top module: `pkt_page_mmu`

## Requirements
- R1: After reset every page is free (freeCount = 4). All queues are empty, allocResult = 0x00 and allocIrq = 0.
- R2: Opcode 1 (allocate for transmit) takes the lowest-numbered free page and marks it used. It puts the page number in allocResult, decrements freeCount and sets allocIrq.
- R3: Opcode 1 with no free page sets allocResult to the failure code 0x80, clears allocIrq and leaves the request pending. The next page release immediately grants the lowest free page, updates allocResult and sets allocIrq.
- R4: The opcode is cmdByte bits 7:5. Bits 4:0 have no effect.
- R5: Opcode 6 appends the packet-number register to the transmit queue. A push onto a full transmit queue (4 entries) is dropped.
- R6: A txSentReq pulse moves the transmit queue head to the tail of the completion queue. A doneAckReq pulse removes the completion queue head.
- R7: rxAllocReq takes the lowest free page and appends it to the receive queue. The request is honoured only while rxReady is high, which requires at least one free page and a receive queue that is not full.
- R8: Opcode 3 pops the receive queue without freeing the page. Opcode 4 pops it and frees the popped page.
- R9: Opcode 5 frees the page named by the packet-number register.
- R10: Opcode 2 empties all three queues, frees every page and cancels a pending allocate. Opcode 7 empties only the transmit and completion queues.
- R11: A queue head output reads 0x80 while its queue is empty. A pop from an empty queue changes nothing.
- R12: Only one operation takes effect per cycle, in this order of precedence: a command write, then rxAllocReq, then txSentReq, then doneAckReq. Lower-ranked requests in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdWrite | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte, opcode in bits 7:5 |
| pktNumWrite | input | 1 | Load strobe for the packet-number register |
| pktNumIn | input | 2 | New packet-number value |
| rxAllocReq | input | 1 | Receive side asks for a page |
| txSentReq | input | 1 | Transmit engine finished the head frame |
| doneAckReq | input | 1 | Host acknowledges the completion head |
| rxReady | output | 1 | A receive allocation would succeed |
| allocResult | output | 8 | Last transmit allocate result, 0x80 on failure |
| allocIrq | output | 1 | Allocation-done flag |
| txHead | output | 8 | Transmit queue head, 0x80 if empty |
| doneHead | output | 8 | Completion queue head, 0x80 if empty |
| rxHead | output | 8 | Receive queue head, 0x80 if empty |
| freeCount | output | 3 | Number of unallocated pages |
| txLen | output | 3 | Transmit queue length |
| doneLen | output | 3 | Completion queue length |
| rxLen | output | 3 | Receive queue length |

## Verification
Several rules are checked on every cycle by the assertions:
- the empty-head code;
- the consistency of rxReady with the free count and the receive length;
- one-page decrement on a successful allocate;
- the failure code and cleared flag on a full pool;
- the dropped push onto a full transmit queue;
- opcode 7 leaving the receive queue alone.

Other behaviour shows only through the bench's scenarios:
- the lowest-free ordering;
- the retry that fires on a later release;
- the exact page numbers that reach each queue;
- the precedence between simultaneous requests.

// File: rtl/pkt_mmu_pkg.sv
package pkt_mmu_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_ALLOC_TX   = 3'd1,
    OP_RESET_ALL  = 3'd2,
    OP_POP_RX     = 3'd3,
    OP_POP_RX_REL = 3'd4,
    OP_RELEASE    = 3'd5,
    OP_PUSH_TX    = 3'd6,
    OP_CLEAR_TX   = 3'd7
  } mmu_op_e;

  typedef struct packed {
    logic allocTx;
    logic resetAll;
    logic popRx;
    logic releaseRx;
    logic releasePkt;
    logic pushTx;
    logic clearTx;
    logic rxAlloc;
    logic txSent;
    logic doneAck;
  } mmu_strobe_t;

  localparam logic [7:0] FAIL_CODE  = 8'h80;
  localparam logic [7:0] EMPTY_CODE = 8'h80;

endpackage

// File: rtl/pkt_mmu_ctrl.sv
module pkt_mmu_ctrl
  import pkt_mmu_pkg::*;
(
  input  logic        cmdWrite,
  input  logic [2:0]  cmdOp,
  input  logic        rxAllocReq,
  input  logic        rxReady,
  input  logic        txSentReq,
  input  logic        doneAckReq,
  output mmu_strobe_t strobes
);

  mmu_op_e op;
  assign op = mmu_op_e'(cmdOp);

  // One operation per cycle: command, then rx alloc, then sent, then ack.
  always_comb begin
    strobes = '0;
    if (cmdWrite) begin
      case (op)
        OP_ALLOC_TX:   strobes.allocTx    = 1'b1;
        OP_RESET_ALL:  strobes.resetAll   = 1'b1;
        OP_POP_RX:     strobes.popRx      = 1'b1;
        OP_POP_RX_REL: strobes.releaseRx  = 1'b1;
        OP_RELEASE:    strobes.releasePkt = 1'b1;
        OP_PUSH_TX:    strobes.pushTx     = 1'b1;
        OP_CLEAR_TX:   strobes.clearTx    = 1'b1;
        default:       strobes            = '0;
      endcase
    end else if (rxAllocReq) begin
      strobes.rxAlloc = rxReady;
    end else if (txSentReq) begin
      strobes.txSent = 1'b1;
    end else if (doneAckReq) begin
      strobes.doneAck = 1'b1;
    end
  end

endmodule

// File: rtl/pkt_mmu_queue.sv
module pkt_mmu_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 2,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] headData,
  output logic [LW-1:0] len,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] slots [DEPTH];
  logic          doPop;
  logic          doPush;
  logic [LW-1:0] wrIdx;

  assign empty    = (len == '0);
  assign full     = (len == LW'(DEPTH));
  assign headData = slots[0];
  assign doPop    = pop && !empty;
  assign doPush   = push && (!full || doPop);
  assign wrIdx    = doPop ? len - LW'(1) : len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (clear) begin
      len <= '0;
    end else begin
      if (doPop) begin
        for (int i = 0; i < DEPTH - 1; i++) slots[i] <= slots[i + 1];
      end
      if (doPush) slots[wrIdx[IW-1:0]] <= pushData;
      if (doPush && !doPop)      len <= len + LW'(1);
      else if (doPop && !doPush) len <= len - LW'(1);
    end
  end

endmodule

// File: rtl/pkt_mmu_pool.sv
module pkt_mmu_pool
  import pkt_mmu_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PW = $clog2(NUM_PAGES),
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 resetAll,
  input  logic                 allocTx,
  input  logic                 rxAlloc,
  input  logic                 relEn,
  input  logic [PW-1:0]        relPage,
  output logic [NUM_PAGES-1:0] pageMap,
  output logic [CW-1:0]        freeCount,
  output logic [7:0]           allocResult,
  output logic                 allocIrq,
  output logic [PW-1:0]        rxPage,
  output logic                 anyFree
);

  logic [NUM_PAGES-1:0] relMask;
  logic [NUM_PAGES-1:0] mapRel;
  logic [PW-1:0]        freeIdx;
  logic [PW-1:0]        relFreeIdx;
  logic                 relAnyFree;
  logic                 allocPend;

  always_comb begin
    relMask          = '0;
    relMask[relPage] = relEn;
    mapRel           = pageMap & ~relMask;
  end

  // Lowest free page: scan downward so the smallest index wins.
  always_comb begin
    freeIdx    = '0;
    relFreeIdx = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!pageMap[i]) freeIdx    = PW'(i);
      if (!mapRel[i])  relFreeIdx = PW'(i);
    end
  end

  always_comb begin
    freeCount = '0;
    for (int i = 0; i < NUM_PAGES; i++) freeCount = freeCount + CW'(!pageMap[i]);
  end

  assign anyFree    = ~&pageMap;
  assign relAnyFree = ~&mapRel;
  assign rxPage     = freeIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pageMap     <= '0;
      allocResult <= '0;
      allocIrq    <= 1'b0;
      allocPend   <= 1'b0;
    end else if (resetAll) begin
      pageMap   <= '0;
      allocPend <= 1'b0;
    end else if (allocTx) begin
      if (anyFree) begin
        pageMap[freeIdx] <= 1'b1;
        allocResult      <= {{(8-PW){1'b0}}, freeIdx};
        allocIrq         <= 1'b1;
        allocPend        <= 1'b0;
      end else begin
        allocResult <= FAIL_CODE;
        allocIrq    <= 1'b0;
        allocPend   <= 1'b1;
      end
    end else if (relEn) begin
      if (allocPend && relAnyFree) begin
        pageMap             <= mapRel;
        pageMap[relFreeIdx] <= 1'b1;
        allocResult         <= {{(8-PW){1'b0}}, relFreeIdx};
        allocIrq            <= 1'b1;
        allocPend           <= 1'b0;
      end else begin
        pageMap <= mapRel;
      end
    end else if (rxAlloc && anyFree) begin
      pageMap[freeIdx] <= 1'b1;
    end
  end

endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
  import pkt_mmu_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PW = $clog2(NUM_PAGES),
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmdWrite,
  input  logic [7:0]    cmdByte,
  input  logic          pktNumWrite,
  input  logic [PW-1:0] pktNumIn,
  input  logic          rxAllocReq,
  input  logic          txSentReq,
  input  logic          doneAckReq,
  output logic          rxReady,
  output logic [7:0]    allocResult,
  output logic          allocIrq,
  output logic [7:0]    txHead,
  output logic [7:0]    doneHead,
  output logic [7:0]    rxHead,
  output logic [CW-1:0] freeCount,
  output logic [CW-1:0] txLen,
  output logic [CW-1:0] doneLen,
  output logic [CW-1:0] rxLen
);

  mmu_strobe_t          strobes;
  logic [PW-1:0]        pktNumReg;
  logic [NUM_PAGES-1:0] pageMap;
  logic [PW-1:0]        rxPage;
  logic                 anyFree;
  logic [PW-1:0]        txData, doneData, rxData;
  logic                 txFull, txEmpty, doneFull, doneEmpty, rxFull, rxEmpty;
  logic                 relEn;
  logic [PW-1:0]        relPage;
  logic                 unusedBits;

  assign unusedBits = ^{cmdByte[4:0], pageMap, txFull, doneFull};

  always_ff @(posedge clk) begin
    if (!rst_n)           pktNumReg <= '0;
    else if (pktNumWrite) pktNumReg <= pktNumIn;
  end

  assign rxReady = anyFree && !rxFull;
  assign relEn   = strobes.releasePkt || (strobes.releaseRx && !rxEmpty);
  assign relPage = strobes.releasePkt ? pktNumReg : rxData;

  pkt_mmu_ctrl u_ctrl (
    .cmdWrite   (cmdWrite),
    .cmdOp      (cmdByte[7:5]),
    .rxAllocReq (rxAllocReq),
    .rxReady    (rxReady),
    .txSentReq  (txSentReq),
    .doneAckReq (doneAckReq),
    .strobes    (strobes)
  );

  pkt_mmu_pool #(.NUM_PAGES(NUM_PAGES)) u_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .resetAll    (strobes.resetAll),
    .allocTx     (strobes.allocTx),
    .rxAlloc     (strobes.rxAlloc),
    .relEn       (relEn),
    .relPage     (relPage),
    .pageMap     (pageMap),
    .freeCount   (freeCount),
    .allocResult (allocResult),
    .allocIrq    (allocIrq),
    .rxPage      (rxPage),
    .anyFree     (anyFree)
  );

  pkt_mmu_queue #(.DEPTH(NUM_PAGES), .DW(PW)) u_txQ (
    .clk (clk), .rst_n (rst_n),
    .clear    (strobes.resetAll || strobes.clearTx),
    .push     (strobes.pushTx),
    .pushData (pktNumReg),
    .pop      (strobes.txSent),
    .headData (txData), .len (txLen), .full (txFull), .empty (txEmpty)
  );

  pkt_mmu_queue #(.DEPTH(NUM_PAGES), .DW(PW)) u_doneQ (
    .clk (clk), .rst_n (rst_n),
    .clear    (strobes.resetAll || strobes.clearTx),
    .push     (strobes.txSent && !txEmpty),
    .pushData (txData),
    .pop      (strobes.doneAck),
    .headData (doneData), .len (doneLen), .full (doneFull), .empty (doneEmpty)
  );

  pkt_mmu_queue #(.DEPTH(NUM_PAGES), .DW(PW)) u_rxQ (
    .clk (clk), .rst_n (rst_n),
    .clear    (strobes.resetAll),
    .push     (strobes.rxAlloc),
    .pushData (rxPage),
    .pop      (strobes.popRx || strobes.releaseRx),
    .headData (rxData), .len (rxLen), .full (rxFull), .empty (rxEmpty)
  );

  assign txHead   = txEmpty   ? EMPTY_CODE : {{(8-PW){1'b0}}, txData};
  assign doneHead = doneEmpty ? EMPTY_CODE : {{(8-PW){1'b0}}, doneData};
  assign rxHead   = rxEmpty   ? EMPTY_CODE : {{(8-PW){1'b0}}, rxData};

endmodule

// File: rtl/pkt_mmu_checker.sv
module pkt_mmu_checker #(
  parameter int NUM_PAGES = 4,
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmdWrite,
  input logic [2:0]    cmdOp,
  input logic          rxReady,
  input logic [7:0]    allocResult,
  input logic          allocIrq,
  input logic [7:0]    doneHead,
  input logic [7:0]    rxHead,
  input logic [CW-1:0] freeCount,
  input logic [CW-1:0] txLen,
  input logic [CW-1:0] doneLen,
  input logic [CW-1:0] rxLen
);

  p_alloc_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrite && cmdOp == 3'd1 && freeCount != '0) |=> freeCount == $past(freeCount) - CW'(1));

  p_fail_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrite && cmdOp == 3'd1 && freeCount == '0) |=> (allocResult == 8'h80 && !allocIrq));

  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrite && cmdOp == 3'd6 && txLen == CW'(NUM_PAGES)) |=> txLen == CW'(NUM_PAGES));

  p_rx_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxReady |-> (freeCount != '0 && rxLen < CW'(NUM_PAGES)));

  p_clear_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrite && cmdOp == 3'd7) |=> (txLen == '0 && doneLen == '0 && $stable(rxLen)));

  p_empty_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rxLen == '0) |-> rxHead == 8'h80);

  p_empty_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (doneLen == '0) |-> doneHead == 8'h80);

endmodule

bind pkt_page_mmu pkt_mmu_checker #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmdWrite    (cmdWrite),
  .cmdOp       (cmdByte[7:5]),
  .rxReady     (rxReady),
  .allocResult (allocResult),
  .allocIrq    (allocIrq),
  .doneHead    (doneHead),
  .rxHead      (rxHead),
  .freeCount   (freeCount),
  .txLen       (txLen),
  .doneLen     (doneLen),
  .rxLen       (rxLen)
);

// File: tb/sim_pkt_page_mmu.sv
`timescale 1ns/1ps
module sim_pkt_page_mmu;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [7:0] cmdByte = '0;
  logic       pktNumWrite = 1'b0;
  logic [1:0] pktNumIn = '0;
  logic       rxAllocReq = 1'b0;
  logic       txSentReq = 1'b0;
  logic       doneAckReq = 1'b0;
  logic       rxReady, allocIrq;
  logic [7:0] allocResult, txHead, doneHead, rxHead;
  logic [2:0] freeCount, txLen, doneLen, rxLen;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pkt_page_mmu u0 (
    .clk (clk), .rst_n (rst_n), .cmdWrite (cmdWrite), .cmdByte (cmdByte),
    .pktNumWrite (pktNumWrite), .pktNumIn (pktNumIn), .rxAllocReq (rxAllocReq),
    .txSentReq (txSentReq), .doneAckReq (doneAckReq), .rxReady (rxReady),
    .allocResult (allocResult), .allocIrq (allocIrq), .txHead (txHead),
    .doneHead (doneHead), .rxHead (rxHead), .freeCount (freeCount),
    .txLen (txLen), .doneLen (doneLen), .rxLen (rxLen)
  );

  // {cmdByte, pktNum, expected allocResult, expected freeCount, expected allocIrq}
  localparam int NVEC = 11;
  localparam logic [21:0] VEC [NVEC] = '{
    {8'h20, 2'd0, 8'h00, 3'd3, 1'b1},
    {8'h3F, 2'd0, 8'h01, 3'd2, 1'b1},
    {8'h20, 2'd0, 8'h02, 3'd1, 1'b1},
    {8'h20, 2'd0, 8'h03, 3'd0, 1'b1},
    {8'h20, 2'd0, 8'h80, 3'd0, 1'b0},
    {8'hA0, 2'd2, 8'h02, 3'd0, 1'b1},
    {8'hA0, 2'd0, 8'h02, 3'd1, 1'b1},
    {8'h20, 2'd0, 8'h00, 3'd0, 1'b1},
    {8'h1F, 2'd0, 8'h00, 3'd0, 1'b1},
    {8'h40, 2'd0, 8'h00, 3'd4, 1'b1},
    {8'h27, 2'd0, 8'h00, 3'd3, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setPkt(input logic [1:0] n);
    @(negedge clk); pktNumWrite = 1'b1; pktNumIn = n;
    @(negedge clk); pktNumWrite = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); cmdWrite = 1'b1; cmdByte = b;
    @(negedge clk); cmdWrite = 1'b0;
  endtask

  task automatic pulse(input logic rx, input logic sent, input logic ack);
    @(negedge clk); rxAllocReq = rx; txSentReq = sent; doneAckReq = ack;
    @(negedge clk); rxAllocReq = 1'b0; txSentReq = 1'b0; doneAckReq = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 freeCount", freeCount, 4);
    chk("R1 allocResult", allocResult, 0);
    chk("R1 allocIrq", allocIrq, 0);
    chk("R1 rxHead", rxHead, 8'h80);
    chk("R1 txHead", txHead, 8'h80);
    chk("R1 doneLen", doneLen, 0);

    // R2 R3 R4 R9 R10: allocator vector walk
    for (int i = 0; i < NVEC; i++) begin
      setPkt(VEC[i][13:12]);
      cmd(VEC[i][21:14]);
      chk("R2/R3 allocResult", allocResult, VEC[i][11:4]);
      chk("R2/R9 freeCount", freeCount, VEC[i][3:1]);
      chk("R3 allocIrq", allocIrq, VEC[i][0]);
    end

    // R7 R8: receive side
    cmd(8'h40);
    for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0, 1'b0);
    chk("R7 rxLen", rxLen, 4);
    chk("R7 rxHead", rxHead, 0);
    chk("R7 rxReady", rxReady, 0);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R7 rxLen when not ready", rxLen, 4);
    cmd(8'h60);
    chk("R8 pop rxHead", rxHead, 1);
    chk("R8 pop keeps page", freeCount, 0);
    cmd(8'h80);
    chk("R8 pop-release rxHead", rxHead, 2);
    chk("R8 pop-release frees", freeCount, 1);
    chk("R7 rxReady again", rxReady, 1);

    // R3: pending allocate retried by opcode 4 release
    cmd(8'h20);
    chk("R2 alloc takes page 1", allocResult, 1);
    cmd(8'h20);
    chk("R3 fail code", allocResult, 8'h80);
    cmd(8'h80);
    chk("R3 retry result", allocResult, 2);
    chk("R3 retry irq", allocIrq, 1);
    chk("R3 retry free", freeCount, 0);
    chk("R8 rxLen", rxLen, 1);

    // R10 R11: reset then pop empty
    cmd(8'h40);
    chk("R10 reset rxLen", rxLen, 0);
    chk("R10 reset free", freeCount, 4);
    cmd(8'h60);
    chk("R11 pop empty rxLen", rxLen, 0);
    chk("R11 empty rxHead", rxHead, 8'h80);

    // R5 R6: transmit and completion queues
    setPkt(2'd1); cmd(8'hC0);
    setPkt(2'd3); cmd(8'hC0);
    setPkt(2'd0); cmd(8'hC0);
    setPkt(2'd2); cmd(8'hC0);
    setPkt(2'd1); cmd(8'hC0);
    chk("R5 full drop txLen", txLen, 4);
    chk("R5 txHead", txHead, 1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 txHead after sent", txHead, 3);
    chk("R6 doneHead", doneHead, 1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 doneLen", doneLen, 2);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R6 doneHead after ack", doneHead, 3);
    pulse(1'b1, 1'b0, 1'b0);
    cmd(8'hE0);
    chk("R10 op7 txLen", txLen, 0);
    chk("R10 op7 doneHead", doneHead, 8'h80);
    chk("R10 op7 keeps rxLen", rxLen, 1);
    chk("R10 op7 keeps free", freeCount, 3);

    // R12: command beats rx request in the same cycle
    cmd(8'h40);
    @(negedge clk); cmdWrite = 1'b1; cmdByte = 8'h20; rxAllocReq = 1'b1;
    @(negedge clk); cmdWrite = 1'b0; rxAllocReq = 1'b0;
    chk("R12 alloc result", allocResult, 0);
    chk("R12 rx ignored", rxLen, 0);
    chk("R12 free", freeCount, 3);
    // R12: rx request beats sent strobe
    setPkt(2'd3); cmd(8'hC0);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R12 rx taken", rxLen, 1);
    chk("R12 sent ignored", txLen, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule